// File: doc/BRIEF.md
# SPI Master Interrupt Status and Mask Unit

This block gathers the interrupt causes of a FIFO-based SPI master into one 7-bit status word and drives a single level interrupt. Three causes are events. The transmit underflow, receive overflow and mode-fail pulses each set a bit that stays set until software clears it. The other four causes are levels. They are re-derived every cycle from the FIFO occupancy counts and full flags: receive full, transmit full, receive count at or above a programmable limit, and transmit count below a programmable limit.

Software reaches the unit through a small register port with address, write strobe, write data, read strobe and read data. Reading the status word returns it and clears it. Writing it clears the bits written as one. The interrupt mask is never written directly. One address sets mask bits and another clears them, and a read-only address shows the result. Two limit registers hold the receive and transmit thresholds. While the controller runs in linear (memory-mapped flash read) mode, a mode input freezes the status word.

Top module: `spi_irq_status`

## Requirements
- R1: Under reset the status word and the mask are 0, both limit registers are 1, and `irq` is 0.
- R2: The sticky bits are bit 6 (transmit underflow, `ev_tx_underflow`), bit 1 (mode fail, `ev_mode_fail`) and bit 0 (receive overflow, `ev_rx_overflow`). A one-cycle pulse sets its bit at the next clock edge. The bit then stays set until software clears it.
- R3: The level bits are recomputed every cycle. Bit 5 equals `rx_full`. Bit 3 equals `tx_full`. Bit 4 is 1 when `rx_count` >= receive limit. Bit 2 is 1 when `tx_count` < transmit limit.
- R4: A read at address 0 returns the status word in bits 6:0 with all upper bits 0. The clock edge of that read clears every status bit. A level bit whose condition still holds is back one cycle later.
- R5: A write at address 0 clears each status bit whose write-data bit is 1 and leaves the others.
- R6: A write at address 1 ORs wdata[6:0] into the mask. A write at address 2 clears the mask bits set in wdata[6:0]. Address 3 reads the mask and ignores writes. Addresses 1 and 2 read as 0.
- R7: Address 4 holds the transmit limit and address 5 the receive limit. Each is CNT_W bits wide, takes wdata[CNT_W-1:0] and reads back zero-extended.
- R8: `irq` is a register. It is 1 exactly one cycle after (mask AND status) is non-zero.
- R9: When an event pulse meets a read or a write-1 clear of its own bit in the same cycle, the bit ends up set.
- R10: While `linear_mode` is 1, the status word holds its value. Events, level changes, reads and clear writes all leave it as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_full | input | 1 | Transmit FIFO full |
| rx_full | input | 1 | Receive FIFO full |
| ev_tx_underflow | input | 1 | Transmit underflow event pulse |
| ev_rx_overflow | input | 1 | Receive overflow event pulse |
| ev_mode_fail | input | 1 | Mode-fail event pulse |
| linear_mode | input | 1 | Freezes status updates |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | DATA_W | Read data, combinational, 0 when no read |
| irq | output | 1 | Registered interrupt level |

## Verification
An event pulse and a software clear of the same sticky bit can fall in the same cycle. The clear can come from a status read or from a write-1. The bench raises the underflow or overflow pulse together with the read strobe, and in another case together with a write-1 to that bit. It then judges the outcome with a later status read, which must still show the bit while the level bits have returned. A second coincidence is a read-clear against a level condition that stays true. Two back-to-back reads show the bit at 0 in the cycle right after the clear and set again one cycle later.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int STAT_W = 7;
    localparam int ADDR_W = 3;
    localparam int NUM_LIMITS = 2;
    localparam int LIM_TX = 0;
    localparam int LIM_RX = 1;

    // Bit order is the software-visible status layout (bit 6 down to bit 0).
    typedef struct packed {
        logic tx_underflow;
        logic rx_full;
        logic rx_reached;
        logic tx_full;
        logic tx_below;
        logic mode_fail;
        logic rx_overflow;
    } irq_vec_t;

    localparam logic [STAT_W-1:0] STICKY_BITS = 7'b100_0011;

    localparam logic [ADDR_W-1:0] A_STATUS   = 3'd0;
    localparam logic [ADDR_W-1:0] A_MASK_SET = 3'd1;
    localparam logic [ADDR_W-1:0] A_MASK_CLR = 3'd2;
    localparam logic [ADDR_W-1:0] A_MASK     = 3'd3;
    localparam logic [ADDR_W-1:0] A_TX_LIMIT = 3'd4;
    localparam logic [ADDR_W-1:0] A_RX_LIMIT = 3'd5;

    typedef struct packed {
        logic                  status_rd;
        logic [STAT_W-1:0]     status_w1c;
        logic [STAT_W-1:0]     mask_set;
        logic [STAT_W-1:0]     mask_clr;
        logic [NUM_LIMITS-1:0] limit_we;
    } reg_strobe_t;

    function automatic irq_vec_t pack_events(logic underflow, logic modefail, logic overflow);
        irq_vec_t v;
        v              = '0;
        v.tx_underflow = underflow;
        v.mode_fail    = modefail;
        v.rx_overflow  = overflow;
        return v;
    endfunction

    function automatic irq_vec_t pack_levels(logic rxf, logic rxr, logic txf, logic txb);
        irq_vec_t v;
        v            = '0;
        v.rx_full    = rxf;
        v.rx_reached = rxr;
        v.tx_full    = txf;
        v.tx_below   = txb;
        return v;
    endfunction

endpackage

// File: rtl/spi_irq_regif.sv
module spi_irq_regif
    import spi_irq_pkg::*;
#(
    parameter int CNT_W  = 7,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_rd,
    input  irq_vec_t          status_q,
    input  logic [STAT_W-1:0] mask_q,
    input  logic [CNT_W-1:0]  tx_limit,
    input  logic [CNT_W-1:0]  rx_limit,
    output reg_strobe_t       strobe,
    output logic [DATA_W-1:0] reg_rdata
);

    logic [STAT_W-1:0] wbits;
    assign wbits = reg_wdata[STAT_W-1:0];

    always_comb begin
        strobe            = '0;
        strobe.status_rd  = reg_rd && (reg_addr == A_STATUS);
        if (reg_wr) begin
            case (reg_addr)
                A_STATUS:   strobe.status_w1c       = wbits;
                A_MASK_SET: strobe.mask_set         = wbits;
                A_MASK_CLR: strobe.mask_clr         = wbits;
                A_TX_LIMIT: strobe.limit_we[LIM_TX] = 1'b1;
                A_RX_LIMIT: strobe.limit_we[LIM_RX] = 1'b1;
                default:    ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                A_STATUS:   reg_rdata[STAT_W-1:0] = status_q;
                A_MASK:     reg_rdata[STAT_W-1:0] = mask_q;
                A_TX_LIMIT: reg_rdata[CNT_W-1:0]  = tx_limit;
                A_RX_LIMIT: reg_rdata[CNT_W-1:0]  = rx_limit;
                default:    reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/spi_irq_limits.sv
module spi_irq_limits
    import spi_irq_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_LIMITS-1:0] limit_we,
    input  logic [CNT_W-1:0]      limit_wdata,
    output logic [CNT_W-1:0]      tx_limit,
    output logic [CNT_W-1:0]      rx_limit
);

    localparam logic [CNT_W-1:0] LIMIT_RESET = CNT_W'(1);

    logic [NUM_LIMITS-1:0][CNT_W-1:0] lim_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_LIMITS; i++) lim_q[i] <= LIMIT_RESET;
        end else begin
            for (int i = 0; i < NUM_LIMITS; i++) begin
                if (limit_we[i]) lim_q[i] <= limit_wdata;
            end
        end
    end

    assign tx_limit = lim_q[LIM_TX];
    assign rx_limit = lim_q[LIM_RX];

endmodule

// File: rtl/spi_irq_mask_reg.sv
module spi_irq_mask_reg
    import spi_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] mask_set,
    input  logic [STAT_W-1:0] mask_clr,
    output logic [STAT_W-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= (mask_q & ~mask_clr) | mask_set;
    end

endmodule

// File: rtl/spi_irq_status_core.sv
module spi_irq_status_core
    import spi_irq_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              tx_full,
    input  logic              rx_full,
    input  logic              ev_tx_underflow,
    input  logic              ev_rx_overflow,
    input  logic              ev_mode_fail,
    input  logic              linear_mode,
    input  logic [CNT_W-1:0]  tx_limit,
    input  logic [CNT_W-1:0]  rx_limit,
    input  logic [STAT_W-1:0] clr_vec,
    output irq_vec_t          status_q
);

    irq_vec_t          levels;
    irq_vec_t          events;
    logic [STAT_W-1:0] kept;
    logic [STAT_W-1:0] status_d;

    always_comb begin
        levels = pack_levels(rx_full, rx_count >= rx_limit, tx_full, tx_count < tx_limit);
        events = pack_events(ev_tx_underflow, ev_mode_fail, ev_rx_overflow);
        kept   = status_q & STICKY_BITS & ~clr_vec;
        // Events are ORed after the clear so a coinciding pulse is kept.
        if (linear_mode) status_d = status_q;
        else             status_d = kept | events | (levels & ~clr_vec);
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= irq_vec_t'(status_d);
    end

endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
    import spi_irq_pkg::*;
#(
    parameter int CNT_W  = 7,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              tx_full,
    input  logic              rx_full,
    input  logic              ev_tx_underflow,
    input  logic              ev_rx_overflow,
    input  logic              ev_mode_fail,
    input  logic              linear_mode,
    input  logic [2:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    reg_strobe_t       strobe;
    irq_vec_t          status_q;
    logic [STAT_W-1:0] mask_q;
    logic [STAT_W-1:0] clr_vec;
    logic [CNT_W-1:0]  tx_limit;
    logic [CNT_W-1:0]  rx_limit;

    spi_irq_regif #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regif (
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rd   (reg_rd),
        .status_q (status_q),
        .mask_q   (mask_q),
        .tx_limit (tx_limit),
        .rx_limit (rx_limit),
        .strobe   (strobe),
        .reg_rdata(reg_rdata)
    );

    spi_irq_limits #(.CNT_W(CNT_W)) u_limits (
        .clk        (clk),
        .rst        (rst),
        .limit_we   (strobe.limit_we),
        .limit_wdata(reg_wdata[CNT_W-1:0]),
        .tx_limit   (tx_limit),
        .rx_limit   (rx_limit)
    );

    spi_irq_mask_reg u_mask (
        .clk     (clk),
        .rst     (rst),
        .mask_set(strobe.mask_set),
        .mask_clr(strobe.mask_clr),
        .mask_q  (mask_q)
    );

    assign clr_vec = strobe.status_rd ? {STAT_W{1'b1}} : strobe.status_w1c;

    spi_irq_status_core #(.CNT_W(CNT_W)) u_core (
        .clk            (clk),
        .rst            (rst),
        .tx_count       (tx_count),
        .rx_count       (rx_count),
        .tx_full        (tx_full),
        .rx_full        (rx_full),
        .ev_tx_underflow(ev_tx_underflow),
        .ev_rx_overflow (ev_rx_overflow),
        .ev_mode_fail   (ev_mode_fail),
        .linear_mode    (linear_mode),
        .tx_limit       (tx_limit),
        .rx_limit       (rx_limit),
        .clr_vec        (clr_vec),
        .status_q       (status_q)
    );

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(mask_q & status_q);
    end

endmodule

// File: rtl/spi_irq_status_chk.sv
module spi_irq_status_chk
    import spi_irq_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              ev_tx_underflow,
    input logic              ev_rx_overflow,
    input logic              rx_full,
    input logic              linear_mode,
    input logic [2:0]        reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [6:0]        wbits,
    input logic [STAT_W-1:0] status_q,
    input logic [STAT_W-1:0] mask_q,
    input logic [CNT_W-1:0]  tx_limit,
    input logic              irq
);

    // R2 and R9: an underflow pulse outside linear mode always leaves bit 6 set
    a_r2_underflow_sets: assert property (@(posedge clk) disable iff (rst)
        (ev_tx_underflow && !linear_mode) |=> status_q[6]);

    a_r9_overflow_beats_read: assert property (@(posedge clk) disable iff (rst)
        (ev_rx_overflow && !linear_mode && reg_rd && reg_addr == A_STATUS) |=> status_q[0]);

    // R4: the cycle after a status read holds no level bit
    a_r4_read_clears_levels: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == A_STATUS && !linear_mode) |=> (status_q[5:2] == 4'b0));

    // R3: receive full shows up unless cleared in that cycle
    a_r3_rx_full_level: assert property (@(posedge clk) disable iff (rst)
        (rx_full && !linear_mode && !(reg_rd && reg_addr == A_STATUS)
         && !(reg_wr && reg_addr == A_STATUS && wbits[5])) |=> status_q[5]);

    // R5: write-1 clear of bit 6 without a new pulse
    a_r5_w1c_underflow: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_STATUS && wbits[6] && !ev_tx_underflow && !linear_mode)
        |=> !status_q[6]);

    // R10: linear mode freezes the status word
    a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
        linear_mode |=> $stable(status_q));

    // R6: writes to the read-only mask address leave the mask alone
    a_r6_mask_ro: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_MASK) |=> $stable(mask_q));

    // R7: the transmit limit only moves on its own write
    a_r7_limit_hold: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == A_TX_LIMIT) |=> $stable(tx_limit));

    // R8: with an empty mask the interrupt stays low the next cycle
    a_r8_no_mask_no_irq: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |=> !irq);

endmodule

bind spi_irq_status spi_irq_status_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .ev_tx_underflow(ev_tx_underflow),
    .ev_rx_overflow (ev_rx_overflow),
    .rx_full        (rx_full),
    .linear_mode    (linear_mode),
    .reg_addr       (reg_addr),
    .reg_wr         (reg_wr),
    .reg_rd         (reg_rd),
    .wbits          (reg_wdata[6:0]),
    .status_q       (status_q),
    .mask_q         (mask_q),
    .tx_limit       (tx_limit),
    .irq            (irq)
);

// File: tb/spi_irq_status_bench.sv
module spi_irq_status_bench;

    localparam int CNT_W  = 7;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [CNT_W-1:0]  tx_count = '0;
    logic [CNT_W-1:0]  rx_count = '0;
    logic              tx_full = 1'b0;
    logic              rx_full = 1'b0;
    logic              ev_tx_underflow = 1'b0;
    logic              ev_rx_overflow = 1'b0;
    logic              ev_mode_fail = 1'b0;
    logic              linear_mode = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic              reg_rd = 1'b0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spi_irq_status #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_spi_irq_status (
        .clk(clk), .rst(rst), .tx_count(tx_count), .rx_count(rx_count),
        .tx_full(tx_full), .rx_full(rx_full), .ev_tx_underflow(ev_tx_underflow),
        .ev_rx_overflow(ev_rx_overflow), .ev_mode_fail(ev_mode_fail),
        .linear_mode(linear_mode), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tx_count = '0; rx_count = '0; tx_full = 0; rx_full = 0;
        linear_mode = 0; reg_rd = 0; reg_wr = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #2 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 irq in reset", {31'b0, irq}, 32'h0);
        reg_rd = 1'b1;
        reg_addr = 3'd0; #2 check("R1 status in reset", reg_rdata, 32'h0);
        reg_addr = 3'd3; #2 check("R1 mask in reset", reg_rdata, 32'h0);
        reg_addr = 3'd4; #2 check("R1 tx limit in reset", reg_rdata, 32'h1);
        reg_addr = 3'd5; #2 check("R1 rx limit in reset", reg_rdata, 32'h1);
        reg_rd = 1'b0;
        do_reset();
        read_reg(3'd0, d);
        check("R3 tx count 0 below limit 1", d, 32'h04);
    endtask

    task automatic t_sticky_and_read_clear();
        logic [31:0] s1, s2, s3;
        do_reset();
        @(negedge clk); ev_tx_underflow = 1;
        @(negedge clk); ev_tx_underflow = 0;
        repeat (3) @(negedge clk);
        @(negedge clk);
        reg_addr = 3'd0; reg_rd = 1;
        #2 s1 = reg_rdata;
        @(negedge clk);
        #2 s2 = reg_rdata;
        @(negedge clk); reg_rd = 0;
        check("R2 underflow sticky", s1, 32'h44);
        check("R4 cleared cycle after read", s2, 32'h00);
        read_reg(3'd0, s3);
        check("R4 level back, sticky gone", s3, 32'h04);
    endtask

    task automatic t_write_clear();
        logic [31:0] d;
        do_reset();
        @(negedge clk); ev_mode_fail = 1; ev_rx_overflow = 1;
        @(negedge clk); ev_mode_fail = 0; ev_rx_overflow = 0;
        write_reg(3'd0, 32'h0000_0002);
        read_reg(3'd0, d);
        check("R5 write-1 clears mode fail only", d, 32'h05);
    endtask

    task automatic t_limits();
        logic [31:0] d;
        do_reset();
        write_reg(3'd4, 32'd8);
        write_reg(3'd5, 32'd4);
        read_reg(3'd4, d); check("R7 tx limit readback", d, 32'd8);
        read_reg(3'd5, d); check("R7 rx limit readback", d, 32'd4);
        @(negedge clk); rx_count = 3; tx_count = 7;
        read_reg(3'd0, d); check("R3 rx 3<4, tx 7<8", d, 32'h04);
        @(negedge clk); rx_count = 4; tx_count = 8;
        read_reg(3'd0, d); check("R3 rx 4>=4, tx 8>=8", d, 32'h10);
        @(negedge clk); rx_full = 1; tx_full = 1;
        read_reg(3'd0, d); check("R3 full flags", d, 32'h38);
        @(negedge clk); rx_full = 0; tx_full = 0;
        write_reg(3'd4, 32'hFFFF_FF85);
        read_reg(3'd4, d); check("R7 limit takes low CNT_W bits", d, 32'h05);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        do_reset();
        write_reg(3'd1, 32'h41);
        read_reg(3'd3, d); check("R6 mask set", d, 32'h41);
        write_reg(3'd2, 32'h01);
        read_reg(3'd3, d); check("R6 mask clear", d, 32'h40);
        read_reg(3'd1, d); check("R6 set address reads 0", d, 32'h0);
        read_reg(3'd2, d); check("R6 clear address reads 0", d, 32'h0);
        write_reg(3'd3, 32'h7F);
        read_reg(3'd3, d); check("R6 mask address ignores writes", d, 32'h40);
        write_reg(3'd1, 32'hFFFF_FFFF);
        read_reg(3'd3, d); check("R6 mask only 7 bits", d, 32'h7F);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        do_reset();
        write_reg(3'd1, 32'h40);
        @(negedge clk);
        check("R8 unmasked level no irq", {31'b0, irq}, 32'h0);
        @(negedge clk); ev_tx_underflow = 1;
        @(negedge clk); ev_tx_underflow = 0;
        check("R8 irq one cycle behind status", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R8 irq high", {31'b0, irq}, 32'h1);
        read_reg(3'd0, d);
        check("R8 read sees underflow", d, 32'h44);
        check("R8 irq still high one cycle", {31'b0, irq}, 32'h1);
        @(negedge clk);
        check("R8 irq low after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        do_reset();
        @(negedge clk);
        reg_addr = 3'd0; reg_rd = 1; ev_rx_overflow = 1;
        #2 d = reg_rdata;
        @(negedge clk); reg_rd = 0; ev_rx_overflow = 0;
        check("R9 read value before event", d, 32'h04);
        read_reg(3'd0, d);
        check("R9 event beats read clear", d, 32'h05);
        @(negedge clk);
        reg_addr = 3'd0; reg_wdata = 32'h40; reg_wr = 1; ev_tx_underflow = 1;
        @(negedge clk); reg_wr = 0; ev_tx_underflow = 0;
        read_reg(3'd0, d);
        check("R9 event beats write-1 clear", d, 32'h44);
    endtask

    task automatic t_linear();
        logic [31:0] d;
        do_reset();
        @(negedge clk); linear_mode = 1; rx_full = 1;
        @(negedge clk); ev_tx_underflow = 1;
        @(negedge clk); ev_tx_underflow = 0;
        read_reg(3'd0, d); check("R10 frozen during linear", d, 32'h04);
        read_reg(3'd0, d); check("R10 read does not clear", d, 32'h04);
        @(negedge clk); linear_mode = 0;
        read_reg(3'd0, d); check("R10 resumes, event lost", d, 32'h24);
        rx_full = 0;
    endtask

    initial begin
        t_reset_state();
        t_sticky_and_read_clear();
        t_write_clear();
        t_limits();
        t_mask();
        t_irq();
        t_collision();
        t_linear();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule